// File: doc/BRIEF.md
# Frequency Change Watchdog Controller

This block supervises a clock-frequency change requested by software. When the watchdog enable is set, a single-cycle frequency-change pulse loads a countdown. The countdown length is a 5-bit step count, and each step is a short or a long span of base ticks. If the countdown reaches its end before software disables the watchdog, the block raises a sticky timeout flag. It then enters a locked recovery state. It can also issue a fixed-width, active-low reset request.

Once locked, the block ignores further change pulses. It leaves recovery only when software drops the watchdog enable. A separate control bit asks for a reset pulse on every accepted frequency change, whether or not the watchdog is enabled. The register transport and the frequency arithmetic sit outside this block. Each control is a level input and the flag clear is a write-one strobe.

Top module: `clkchg_watchdog`

## Requirements
- R1: After synchronous reset, `timeout_flag` is 0, `recovery_mode` is 0 and `reset_req_n` is 1.
- R2: With `wd_en` high and base ticks running, no countdown and no timeout happen until a `freq_change` pulse is accepted.
- R3: With `long_scale` = 0, the timeout flag is first seen after the edge that is `(tmo_steps+1)*SHORT_TICKS` base ticks past the edge on which `freq_change` was sampled.
- R4: With `long_scale` = 1, the same count uses `LONG_TICKS` base ticks per step.
- R5: A `freq_change` pulse that arrives while the countdown runs restarts the count from the programmed value and clears the partial step.
- R6: On expiry, `timeout_flag` and `recovery_mode` rise on the same edge. `reset_req_n` goes low on that edge only when `rst_on_expire` is 1.
- R7: `timeout_flag` stays set until a cycle with `status_clr` = 1, and `status_clr` = 0 has no effect. When expiry and clear fall in the same cycle, the flag ends up set. Clearing the flag does not leave recovery.
- R8: While recovery is held and `wd_en` is 1, `freq_change` neither restarts counting nor produces a reset pulse.
- R9: `wd_en` = 0 stops and reloads the countdown and releases recovery on the next edge. Change pulses seen while disabled start no count.
- R10: With `rst_on_change` = 1 and the block not locked, each accepted `freq_change` starts a reset pulse, whatever the value of `wd_en`.
- R11: A reset pulse holds `reset_req_n` low for exactly `RST_CYCLES` cycles. A trigger that arrives during a pulse neither extends it nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Unit timebase strobe, one cycle per tick |
| tmo_steps | input | 5 | Countdown length minus one, in steps |
| long_scale | input | 1 | 0: SHORT_TICKS per step, 1: LONG_TICKS per step |
| wd_en | input | 1 | Watchdog enable; low stops, reloads and unlocks |
| rst_on_expire | input | 1 | Request a reset pulse on expiry |
| rst_on_change | input | 1 | Request a reset pulse on each accepted change |
| status_clr | input | 1 | Write-one strobe clearing the timeout flag |
| freq_change | input | 1 | Single-cycle frequency-change event |
| timeout_flag | output | 1 | Sticky timeout status |
| recovery_mode | output | 1 | Locked recovery state |
| reset_req_n | output | 1 | Active-low reset request, open-drain style |

## Verification
A wrong step or divider count shows at the ports as a timeout edge that comes early or late by whole base ticks. The step-count sweep therefore finds such an error on the exact cycle of the first run that uses the faulty length. A lock state that does not hold, or that clears itself, shows as `recovery_mode` changing while `wd_en` is steady. The symptom appears at most one edge after the faulty transition. A pulse-counter fault shows on the cycle the reset request is released, as a low run that is not exactly `RST_CYCLES` long.

// File: rtl/clkchg_wd_pkg.sv
package clkchg_wd_pkg;

    localparam int TMO_W = 5;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_LOCK = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic restart;
        logic expire;
        logic running;
        logic locked;
    } wd_evt_t;

    function automatic logic [TMO_W:0] load_steps(input logic [TMO_W-1:0] v);
        return {1'b0, v} + {{TMO_W{1'b0}}, 1'b1};
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wd_step_div.sv
module wd_step_div #(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500,
    parameter int DIV_W       = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic long_sel,
    output logic step
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = long_sel ? DIV_W'(LONG_TICKS - 1) : DIV_W'(SHORT_TICKS - 1);
        step  = run && tick && (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            if (step) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wd_core.sv
module wd_core
    import clkchg_wd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic             freq_change,
    input  logic             step,
    input  logic [TMO_W-1:0] tmo_steps,
    input  logic             status_clr,
    output wd_evt_t          evt,
    output logic             flag
);
    wd_state_e        state;
    logic [TMO_W:0]   remain;

    always_comb begin
        evt.locked  = (state == WD_LOCK);
        evt.running = (state == WD_RUN);
        evt.restart = wd_en && freq_change && (state != WD_LOCK);
        evt.expire  = wd_en && !evt.restart && evt.running && step
                      && (remain == {{TMO_W{1'b0}}, 1'b1});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WD_IDLE;
            remain <= '0;
        end else if (!wd_en) begin
            state  <= WD_IDLE;
            remain <= load_steps(tmo_steps);
        end else if (evt.restart) begin
            state  <= WD_RUN;
            remain <= load_steps(tmo_steps);
        end else if (evt.expire) begin
            state  <= WD_LOCK;
            remain <= '0;
        end else if (evt.running && step) begin
            remain <= remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             flag <= 1'b0;
        else if (evt.expire) flag <= 1'b1;
        else if (status_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/wd_rst_pulse.sv
module wd_rst_pulse #(
    parameter int RST_CYCLES = 16,
    parameter int PW         = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    logic [PW-1:0] pcnt;

    assign active = (pcnt != '0);

    always_ff @(posedge clk) begin
        if (rst)                  pcnt <= '0;
        else if (trig && !active) pcnt <= PW'(RST_CYCLES);
        else if (active)          pcnt <= pcnt - 1'b1;
    end
endmodule

// File: rtl/clkchg_watchdog.sv
module clkchg_watchdog
    import clkchg_wd_pkg::*;
#(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500,
    parameter int RST_CYCLES  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic [TMO_W-1:0] tmo_steps,
    input  logic             long_scale,
    input  logic             wd_en,
    input  logic             rst_on_expire,
    input  logic             rst_on_change,
    input  logic             status_clr,
    input  logic             freq_change,
    output logic             timeout_flag,
    output logic             recovery_mode,
    output logic             reset_req_n
);
    localparam int MAX_TICKS = max_int(SHORT_TICKS, LONG_TICKS);
    localparam int DIV_W     = $clog2(MAX_TICKS + 1);
    localparam int PW        = $clog2(RST_CYCLES + 1);

    wd_evt_t evt;
    logic    step;
    logic    pulse_trig;
    logic    pulse_active;

    wd_step_div #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .DIV_W      (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .clear   (evt.restart || !wd_en),
        .run     (evt.running),
        .tick    (base_tick),
        .long_sel(long_scale),
        .step    (step)
    );

    wd_core u_core (
        .clk        (clk),
        .rst        (rst),
        .wd_en      (wd_en),
        .freq_change(freq_change),
        .step       (step),
        .tmo_steps  (tmo_steps),
        .status_clr (status_clr),
        .evt        (evt),
        .flag       (timeout_flag)
    );

    assign pulse_trig = (evt.expire && rst_on_expire)
                      || (freq_change && rst_on_change && !evt.locked);

    wd_rst_pulse #(
        .RST_CYCLES(RST_CYCLES),
        .PW        (PW)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (pulse_trig),
        .active(pulse_active)
    );

    assign recovery_mode = evt.locked;
    assign reset_req_n   = !pulse_active;
endmodule

// File: rtl/clkchg_watchdog_chk.sv
module clkchg_watchdog_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic wd_en,
    input logic status_clr,
    input logic timeout_flag,
    input logic recovery_mode,
    input logic reset_req_n
);
    localparam int LW = $clog2(RST_CYCLES + 2) + 1;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)               low_run <= '0;
        else if (!reset_req_n) low_run <= low_run + 1'b1;
        else                   low_run <= '0;
    end

    assert_lock_with_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(recovery_mode) |-> timeout_flag);

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (recovery_mode && wd_en) |=> recovery_mode);

    assert_disable_unlocks_R9: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !recovery_mode);

    assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(timeout_flag) |-> $past(status_clr));

    assert_pulse_exact_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req_n) |-> (low_run == LW'(RST_CYCLES)));

    assert_pulse_bounded_R11: assert property (@(posedge clk) disable iff (rst)
        low_run <= LW'(RST_CYCLES));
endmodule

bind clkchg_watchdog clkchg_watchdog_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wd_en        (wd_en),
    .status_clr   (status_clr),
    .timeout_flag (timeout_flag),
    .recovery_mode(recovery_mode),
    .reset_req_n  (reset_req_n)
);

// File: tb/clkchg_watchdog_test.sv
module clkchg_watchdog_test;
    localparam int S_SHORT = 2;
    localparam int S_LONG  = 3;
    localparam int RW      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic [4:0] tmo_steps = 5'd0;
    logic       long_scale = 1'b0;
    logic       wd_en = 1'b0;
    logic       rst_on_expire = 1'b0;
    logic       rst_on_change = 1'b0;
    logic       status_clr = 1'b0;
    logic       freq_change = 1'b0;
    logic       timeout_flag, recovery_mode, reset_req_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkchg_watchdog #(
        .SHORT_TICKS(S_SHORT),
        .LONG_TICKS (S_LONG),
        .RST_CYCLES (RW)
    ) uut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .tmo_steps(tmo_steps),
        .long_scale(long_scale), .wd_en(wd_en), .rst_on_expire(rst_on_expire),
        .rst_on_change(rst_on_change), .status_clr(status_clr),
        .freq_change(freq_change), .timeout_flag(timeout_flag),
        .recovery_mode(recovery_mode), .reset_req_n(reset_req_n)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic change_pulse();
        freq_change = 1'b1;
        cyc();
        freq_change = 1'b0;
    endtask

    task automatic count_pulse(input bool_retrig, output int n);
        n = reset_req_n ? 0 : 1;
        for (int i = 0; i < 3 * RW; i++) begin
            if (bool_retrig && i == 1) freq_change = 1'b1;
            cyc();
            freq_change = 1'b0;
            if (!reset_req_n) n++;
            else break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired R1 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int n;
        int exp_k;
        bit en_rst;

        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(timeout_flag == 1'b0, "R1 flag", timeout_flag, 0);
        chk(recovery_mode == 1'b0, "R1 recovery", recovery_mode, 0);
        chk(reset_req_n == 1'b1, "R1 reset_req_n", reset_req_n, 1);

        // R2: enabled, ticking, no change -> no countdown
        wd_en = 1'b1; tmo_steps = 5'd0; base_tick = 1'b1;
        repeat (100) cyc();
        chk(timeout_flag == 1'b0, "R2 no change no timeout", timeout_flag, 0);
        chk(recovery_mode == 1'b0, "R2 no lock", recovery_mode, 0);

        // R5: restart mid-count, v=3 -> 8 cycles
        tmo_steps = 5'd3;
        base_tick = 1'b0;
        change_pulse();
        base_tick = 1'b1;
        repeat (5) cyc();
        chk(timeout_flag == 1'b0, "R5 before restart", timeout_flag, 0);
        change_pulse();
        k = 0;
        for (int i = 0; i < 50; i++) begin
            cyc(); k++;
            if (timeout_flag) break;
        end
        chk(k == 4 * S_SHORT, "R5 restart count", k, 4 * S_SHORT);

        // R7: set wins over clear in same cycle, clear keeps lock
        wd_en = 1'b0; status_clr = 1'b1; base_tick = 1'b0;
        cyc();
        wd_en = 1'b1; tmo_steps = 5'd0;
        change_pulse();
        base_tick = 1'b1;
        cyc();
        chk(timeout_flag == 1'b0, "R7 not yet expired", timeout_flag, 0);
        cyc();
        chk(timeout_flag == 1'b1, "R7 set wins over clear", timeout_flag, 1);
        cyc();
        chk(timeout_flag == 1'b0, "R7 cleared by write one", timeout_flag, 0);
        chk(recovery_mode == 1'b1, "R7 clear keeps recovery", recovery_mode, 1);
        status_clr = 1'b0;

        // R3/R4/R6 sweep over every step count and both scales
        for (int sc = 0; sc < 2; sc++) begin
            for (int v = 0; v < 32; v++) begin
                en_rst = v[0];
                wd_en = 1'b0; status_clr = 1'b1; base_tick = 1'b0;
                cyc();
                chk(recovery_mode == 1'b0, "R9 disable releases", recovery_mode, 0);
                status_clr = 1'b0; wd_en = 1'b1;
                tmo_steps = 5'(v); long_scale = sc[0]; rst_on_expire = en_rst;
                change_pulse();
                base_tick = 1'b1;
                exp_k = (v + 1) * (sc == 0 ? S_SHORT : S_LONG);
                k = 0;
                for (int i = 0; i < 200; i++) begin
                    cyc(); k++;
                    if (timeout_flag) break;
                end
                chk(k == exp_k, sc == 0 ? "R3 short scale timeout" : "R4 long scale timeout",
                    k, exp_k);
                chk(recovery_mode == 1'b1, "R6 recovery with flag", recovery_mode, 1);
                chk(reset_req_n == !en_rst, "R6 reset on expire select", reset_req_n, !en_rst);
                if (en_rst) begin
                    count_pulse(1'b0, n);
                    chk(n == RW, "R11 expiry pulse width", n, RW);
                end else begin
                    cyc();
                    chk(reset_req_n == 1'b1, "R6 no pulse when disabled", reset_req_n, 1);
                end
            end
        end
        long_scale = 1'b0;
        rst_on_expire = 1'b0;

        // R7: zero write has no effect
        repeat (5) cyc();
        chk(timeout_flag == 1'b1, "R7 sticky with clr=0", timeout_flag, 1);

        // R8: locked ignores change pulses
        rst_on_change = 1'b1;
        tmo_steps = 5'd0;
        change_pulse();
        chk(reset_req_n == 1'b1, "R8 no pulse while locked", reset_req_n, 1);
        status_clr = 1'b1; cyc(); status_clr = 1'b0;
        repeat (40) cyc();
        chk(timeout_flag == 1'b0, "R8 no recount while locked", timeout_flag, 0);
        chk(recovery_mode == 1'b1, "R8 lock held", recovery_mode, 1);

        // R9: disable releases; change while disabled starts nothing
        rst_on_change = 1'b0;
        wd_en = 1'b0;
        cyc();
        chk(recovery_mode == 1'b0, "R9 release", recovery_mode, 0);
        change_pulse();
        repeat (40) cyc();
        chk(timeout_flag == 1'b0, "R9 no count while disabled", timeout_flag, 0);
        wd_en = 1'b1;
        repeat (40) cyc();
        chk(timeout_flag == 1'b0, "R9 reenable needs change", timeout_flag, 0);

        // R10/R11: reset on change with watchdog off, retrigger ignored
        wd_en = 1'b0; rst_on_change = 1'b1;
        cyc();
        change_pulse();
        chk(reset_req_n == 1'b0, "R10 pulse on change wd off", reset_req_n, 0);
        count_pulse(1'b1, n);
        chk(n == RW, "R11 retrigger ignored width", n, RW);
        repeat (3) cyc();
        chk(reset_req_n == 1'b1, "R11 no second pulse", reset_req_n, 1);

        // R10 with watchdog on
        wd_en = 1'b1; tmo_steps = 5'd31;
        change_pulse();
        chk(reset_req_n == 1'b0, "R10 pulse on change wd on", reset_req_n, 0);
        count_pulse(1'b0, n);
        chk(n == RW, "R11 change pulse width", n, RW);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule